// File: doc/BRIEF.md
# Coprocessor Address Decoder with Wait States

This block sits between a coprocessor's 24-bit address bus and the memories and registers behind it. Each accepted request is classified into one of six targets: a register window, a banked ROM, an 8 KiB work-RAM window, a 2 KiB internal RAM, a direct work-RAM region and a packed-pixel (bitmap) view. The decoder registers a one-hot select together with the target-local offset, the write flag and the write data. A target therefore sees one consistent request, one cycle after acceptance.

Requests that touch work-RAM run at half speed. The decoder raises a registered `stall` for exactly one extra cycle, and it holds its outputs through that cycle. The requester keeps its request unchanged while it sees `stall` high.

The decoder also keeps a bus-hold register. Every accepted write loads it. A read that reaches no target returns the held value instead of target data. Writes aimed at ROM are dropped: no target is selected for them.

Top module: `cop_addr_decode`

## Requirements
- R1: An address whose bank is 00-3F or 80-BF and whose low 16 bits are 2200-23FF selects the register window (select bit 0), with offset addr[8:0].
- R2: A read at low half 8000-FFFF in banks 00-3F/80-BF, or any address in banks C0-FF, selects ROM (select bit 1). For banks C0-FF the offset is {addr[21:20], addr[19:0]}. For the other ROM banks the offset is {addr[23], addr[21], addr[20:16], addr[14:0]}.
- R3: Low half 6000-7FFF in banks 00-3F/80-BF selects the work-RAM window (select bit 2), with offset addr[12:0].
- R4: Low half 0000-07FF or 3000-37FF in banks 00-3F/80-BF selects internal RAM (select bit 3), with offset addr[10:0].
- R5: Banks 40-4F select direct work-RAM (select bit 4), with offset addr[17:0] at the default 256 KiB size. Banks 60-6F select the bitmap view (select bit 5), with offset addr[19:0].
- R6: A write to a ROM address asserts no select bit. It takes one cycle and still loads the bus-hold register.
- R7: The bus-hold register resets to 0 and is loaded by every accepted write, whatever its region. `rd_data` shows `tgt_rdata` when a select bit is set, and shows the bus-hold value otherwise.
- R8: A request to the work-RAM window, banks 40-4F or banks 60-6F raises `stall` for exactly one cycle after acceptance. Every other request runs with `stall` low.
- R9: Select, offset, write flag and write data appear one cycle after acceptance, with `tgt_valid` high. They stay unchanged through a stall cycle. When no request follows, they return to zero and `tgt_valid` goes low.
- R10: At most one select bit is ever set. After reset all outputs are zero and `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when `stall` is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Coprocessor address |
| req_wdata | input | 8 | Write data |
| stall | output | 1 | Extra wait cycle for a slow access |
| tgt_valid | output | 1 | A decoded access is being presented |
| tgt_sel | output | 6 | One-hot target select |
| tgt_off | output | 22 | Offset within the selected target |
| tgt_we | output | 1 | Registered write flag |
| tgt_wdata | output | 8 | Registered write data |
| tgt_rdata | input | 8 | Read data from the selected target |
| rd_data | output | 8 | Read result returned to the requester |

## Verification
The embedded assertions check on every cycle that:
- at most one target is selected;
- a stall never lasts two cycles;
- outputs stay frozen across a stall;
- a ROM write never reaches ROM;
- the bus-hold register tracks the data of the write being presented.

Only the bench's scenarios can show that each address lands in the right target with the right offset. The same goes for the slow/fast split per region and for an unmapped read returning data left by an earlier write, including a dropped ROM write. The bench compares these against a behavioural model on every clock.

// File: rtl/cad_pkg.sv
package cad_pkg;
  localparam int ADDR_W = 24;
  localparam int NTGT   = 6;
  localparam int T_REG  = 0;
  localparam int T_ROM  = 1;
  localparam int T_WIN  = 2;
  localparam int T_IRAM = 3;
  localparam int T_BWD  = 4;
  localparam int T_BMP  = 5;
  typedef logic [NTGT-1:0] tsel_t;
endpackage

// File: rtl/cad_region_decode.sv
module cad_region_decode
  import cad_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output tsel_t             hit,
  output logic              slow
);
  logic lob;
  assign lob = ~addr[22];

  always_comb begin
    hit = '0;
    if (lob && addr[15:9] == 7'b0010_001) begin
      hit[T_REG] = 1'b1;
    end else if ((lob && addr[15]) || addr[23:22] == 2'b11) begin
      hit[T_ROM] = ~we;
    end else if (lob && addr[15:13] == 3'b011) begin
      hit[T_WIN] = 1'b1;
    end else if (lob && (addr[15:11] == 5'b00000 || addr[15:11] == 5'b00110)) begin
      hit[T_IRAM] = 1'b1;
    end else if (addr[23:20] == 4'h4) begin
      hit[T_BWD] = 1'b1;
    end else if (addr[23:20] == 4'h6) begin
      hit[T_BMP] = 1'b1;
    end
  end

  assign slow = (lob && addr[15:13] == 3'b011) ||
                ({addr[23:22], addr[20]} == 3'b010);
endmodule

// File: rtl/cad_offset_calc.sv
module cad_offset_calc
  import cad_pkg::*;
#(
  parameter int BWRAM_AW = 18,
  parameter int OFF_W    = 22
) (
  input  logic [ADDR_W-1:0] addr,
  input  tsel_t             hit,
  output logic [OFF_W-1:0]  off
);
  logic [1:0]  rom_seg;
  logic [19:0] rom_low;

  always_comb begin
    if (addr[23:22] == 2'b11) begin
      rom_seg = addr[21:20];
      rom_low = addr[19:0];
    end else begin
      rom_seg = {addr[23], addr[21]};
      rom_low = {addr[20:16], addr[14:0]};
    end
  end

  always_comb begin
    off = '0;
    unique case (1'b1)
      hit[T_REG]:  off[8:0]          = addr[8:0];
      hit[T_ROM]:  off[21:0]         = {rom_seg, rom_low};
      hit[T_WIN]:  off[12:0]         = addr[12:0];
      hit[T_IRAM]: off[10:0]         = addr[10:0];
      hit[T_BWD]:  off[BWRAM_AW-1:0] = addr[BWRAM_AW-1:0];
      hit[T_BMP]:  off[19:0]         = addr[19:0];
      default:     off               = '0;
    endcase
  end
endmodule

// File: rtl/cad_wait_ctrl.sv
module cad_wait_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic slow,
  output logic stall
);
  always_ff @(posedge clk) begin
    if (rst) stall <= 1'b0;
    else     stall <= accept & slow;
  end

  // R8: a wait lasts exactly one cycle
  assert_stall_single_R8: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);
endmodule

// File: rtl/cop_addr_decode.sv
module cop_addr_decode
  import cad_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BWRAM_AW = 18,
  parameter int OFF_W    = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [23:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              stall,
  output logic              tgt_valid,
  output logic [5:0]        tgt_sel,
  output logic [OFF_W-1:0]  tgt_off,
  output logic              tgt_we,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic [DATA_W-1:0] tgt_rdata,
  output logic [DATA_W-1:0] rd_data
);
  tsel_t             hit;
  logic              slow;
  logic [OFF_W-1:0]  off_d;
  logic [DATA_W-1:0] hold_q;
  logic              accept;

  assign accept = req_valid & ~stall;

  cad_region_decode u_dec (.addr(req_addr), .we(req_we), .hit(hit), .slow(slow));

  cad_offset_calc #(.BWRAM_AW(BWRAM_AW), .OFF_W(OFF_W)) u_off (
    .addr(req_addr), .hit(hit), .off(off_d));

  cad_wait_ctrl u_wait (.clk(clk), .rst(rst), .accept(accept), .slow(slow), .stall(stall));

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_valid <= 1'b0;
      tgt_sel   <= '0;
      tgt_off   <= '0;
      tgt_we    <= 1'b0;
      tgt_wdata <= '0;
      hold_q    <= '0;
    end else if (accept) begin
      tgt_valid <= 1'b1;
      tgt_sel   <= hit;
      tgt_off   <= off_d;
      tgt_we    <= req_we;
      tgt_wdata <= req_wdata;
      if (req_we) hold_q <= req_wdata;
    end else if (!stall) begin
      tgt_valid <= 1'b0;
      tgt_sel   <= '0;
      tgt_off   <= '0;
      tgt_we    <= 1'b0;
      tgt_wdata <= '0;
    end
  end

  assign rd_data = (|tgt_sel) ? tgt_rdata : hold_q;

  assert_one_target_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_sel));
  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !tgt_valid |-> (tgt_sel == '0 && !stall));
  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    stall |=> (tgt_valid && $stable(tgt_sel) && $stable(tgt_off) && $stable(tgt_wdata)));
  assert_rom_write_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && tgt_we) |-> !tgt_sel[T_ROM]);
  assert_hold_tracks_write_R7: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && tgt_we) |-> (hold_q == tgt_wdata));
endmodule

// File: tb/sim_cop_addr_decode.sv
module sim_cop_addr_decode;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_we;
  logic [23:0] req_addr;
  logic [7:0]  req_wdata;
  logic        stall, tgt_valid, tgt_we;
  logic [5:0]  tgt_sel;
  logic [21:0] tgt_off;
  logic [7:0]  tgt_wdata, tgt_rdata, rd_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] e_hold = 8'h00;

  always #5 clk = ~clk;

  assign tgt_rdata = tgt_off[7:0] ^ 8'h5A;

  cop_addr_decode u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .stall(stall),
    .tgt_valid(tgt_valid), .tgt_sel(tgt_sel), .tgt_off(tgt_off),
    .tgt_we(tgt_we), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
    .rd_data(rd_data));

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic we, input logic [23:0] a,
                       output logic [5:0] s, output logic [21:0] o, output bit slw);
    int bank = int'(a[23:16]);
    int lo   = int'(a[15:0]);
    bit lob  = (bank < 'h40) || (bank >= 'h80 && bank < 'hC0);
    s = 0; o = 0;
    if (lob && lo >= 'h2200 && lo <= 'h23FF) begin
      s = 6'd1; o = 22'(lo - 'h2200);
    end else if ((lob && lo >= 'h8000) || bank >= 'hC0) begin
      if (!we) begin
        s = 6'd2;
        if (bank >= 'hC0) o = 22'((((bank / 16) % 4) * 'h100000) + (int'(a) % 'h100000));
        else o = 22'((((bank / 128) * 2 + (bank / 32) % 2) * 'h100000) + ((bank % 32) * 'h8000) + (lo % 'h8000));
      end
    end else if (lob && lo >= 'h6000) begin
      s = 6'd4; o = 22'(lo - 'h6000);
    end else if (lob && (lo < 'h800 || (lo >= 'h3000 && lo < 'h3800))) begin
      s = 6'd8; o = 22'(lo % 2048);
    end else if (bank >= 'h40 && bank < 'h50) begin
      s = 6'd16; o = 22'(int'(a) % (1 << 18));
    end else if (bank >= 'h60 && bank < 'h70) begin
      s = 6'd32; o = 22'(int'(a) % (1 << 20));
    end
    slw = (lob && lo >= 'h6000 && lo < 'h8000) ||
          (bank >= 'h40 && bank < 'h50) || (bank >= 'h60 && bank < 'h70);
  endtask

  task automatic look(input string tag, input logic we, input logic [5:0] s,
                      input logic [21:0] o, input bit st);
    chk(tag, "valid", tgt_valid, 1);
    chk(tag, "sel", tgt_sel, s);
    chk(tag, "off", tgt_off, o);
    chk(tag, "stall", stall, st);
    chk(tag, "we", tgt_we, we);
    if (!we) chk(tag, "rd_data", rd_data, (s != 0) ? (o[7:0] ^ 8'h5A) : e_hold);
  endtask

  // called at a negedge; leaves the bench at a negedge
  task automatic access(input string tag, input logic we, input logic [23:0] a, input logic [7:0] d);
    logic [5:0] s; logic [21:0] o; bit slw;
    model(we, a, s, o, slw);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (we) e_hold = d;
    look(tag, we, s, o, slw);
    if (we) chk(tag, "wdata", tgt_wdata, d);
    if (slw) begin
      @(negedge clk);
      look(tag, we, s, o, 1'b0);
    end
    req_valid = 1'b0;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    chk(tag, "idle valid", tgt_valid, 0);
    chk(tag, "idle sel", tgt_sel, 0);
    chk(tag, "idle stall", stall, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10", "reset valid", tgt_valid, 0);
    chk("R10", "reset sel", tgt_sel, 0);
    chk("R10", "reset stall", stall, 0);
    chk("R10", "reset rd_data", rd_data, 0);
    access("R7", 1'b0, 24'h7F0000, 8'h00);
    access("R1", 1'b1, 24'h002234, 8'h11);
    access("R7", 1'b1, 24'h500000, 8'hA5);
    access("R7", 1'b0, 24'h702000, 8'h00);
    idle("R9");
    access("R2", 1'b0, 24'h238123, 8'h00);
    access("R2", 1'b0, 24'hE54321, 8'h00);
    access("R2", 1'b0, 24'hBFFFFF, 8'h00);
    access("R6", 1'b1, 24'h008000, 8'h3C);
    access("R6", 1'b0, 24'h7F1234, 8'h00);
    access("R6", 1'b1, 24'hC01234, 8'h77);
    access("R7", 1'b0, 24'h003800, 8'h00);
    access("R3", 1'b0, 24'h816ABC, 8'h00);
    access("R8", 1'b1, 24'h3F7FFF, 8'h42);
    idle("R8");
    access("R4", 1'b1, 24'h0007FF, 8'h99);
    access("R4", 1'b0, 24'hBF3456, 8'h00);
    access("R4", 1'b0, 24'h3F37FF, 8'h00);
    access("R5", 1'b0, 24'h4ABCDE, 8'h00);
    access("R5", 1'b1, 24'h6F1234, 8'h0F);
    access("R5", 1'b0, 24'h402200, 8'h00);
    access("R1", 1'b0, 24'h802300, 8'h00);
    access("R7", 1'b0, 24'h5FFFFF, 8'h00);
    idle("R9");
    idle("R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule